// File: doc/BRIEF.md
# Neighbour-Routed Multiplexer Logic Cell

This block is one tile of a fine-grained sea-of-gates fabric. It takes one signal from each of its four neighbours (north, east, south, west) and drives one signal back to each. Two operand selectors each pick a neighbour signal, and each operand can be inverted. A two-input multiplexer then forms the cell result. Operand A steers it. When A is 1 the result is operand B. When A is 0 the result is a second leg chosen by a 2-bit function code: constant 0, constant 1, inverted B, or the cell's own stored result. The last choice turns the cell into a level-sensitive latch, with A as the enable and B as the data. A build-time parameter replaces that stored value with a clocked copy of the result, which gives an edge-triggered storage cell.

Each of the four outputs has its own 2-bit route code. The code picks either the cell result or the signal arriving from one of the three other sides, so a cell can also serve as a wire crossing. The 16-bit setup word is loaded serially. While a load is in progress, or until a complete word has arrived, every output is held at 0.

Top module: `nbr_cell`

## Requirements
- R1: While `cfg_en` is 1, each rising `clk` edge shifts `cfg_din` into the setup word, most significant bit first. After 16 shifts the word is laid out as follows: [15:14] operand A source, [13:12] operand B source, [11] invert A, [10] invert B, [9:8] function code, [7:6] north route, [5:4] east route, [3:2] south route, [1:0] west route.
- R2: All four outputs are 0 during reset, while `cfg_en` is 1, and whenever fewer than 16 bits have been shifted since `cfg_en` last rose.
- R3: A source code of 0, 1, 2 or 3 selects the north, east, south or west input. When its invert bit is 1, the operand is the complement of that input.
- R4: When A is 1 the result equals B. When A is 0, function code 0 gives 0, code 1 gives 1 and code 2 gives the complement of B.
- R5: With function code 3 in the default build, the result follows B while A is 1 and holds its last value while A is 0.
- R6: With function code 3 and `FEEDBACK_REG`=1, while A is 0 the result equals the value it had at the previous rising `clk` edge.
- R7: Route code 0 drives the cell result. A route code c from 1 to 3 on the side with index d (N=0, E=1, S=2, W=3) drives the input of side (d+c) mod 4.
- R8: If more than 16 bits are shifted during one load, only the last 16 form the setup word.
- R9: Reset clears the stored feedback value to 0.
- R10: A new load may start at any time. The outputs are 0 for its whole duration, and the cell then follows the new word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for setup shifting and for the registered feedback |
| rst_n | input | 1 | Asynchronous active-low reset, released through a synchroniser |
| cfg_en | input | 1 | Shift enable for the setup chain |
| cfg_din | input | 1 | Serial setup data, most significant bit first |
| in_n | input | 1 | Signal from the north neighbour |
| in_e | input | 1 | Signal from the east neighbour |
| in_s | input | 1 | Signal from the south neighbour |
| in_w | input | 1 | Signal from the west neighbour |
| out_n | output | 1 | Signal to the north neighbour |
| out_e | output | 1 | Signal to the east neighbour |
| out_s | output | 1 | Signal to the south neighbour |
| out_w | output | 1 | Signal to the west neighbour |

## Verification
Several properties are checked on every clock:
- the outputs are silent during a load, and each shift places the serial bit at the bottom of the word;
- function code 0 behaves as an AND of the operands;
- route code 1 on the north side passes the east input;
- a south route code of 0 drives the result;
- with the enable low, the result stays steady in feedback mode, and in the registered build it repeats its previous-edge value.

Other behaviour can only be shown by the bench scenarios: full sweeps of every operand source, inversion and route code; latch hold sequences in which the data changes after the enable has dropped; over-length and truncated loads; a reload in the middle of operation; and a reset that clears a stored 1.

// File: rtl/nbr_cell_pkg.sv
package nbr_cell_pkg;
  localparam int NDIR  = 4;
  localparam int SEL_W = $clog2(NDIR);

  typedef enum logic [1:0] {
    FN_ZERO = 2'd0,
    FN_ONE  = 2'd1,
    FN_NOTB = 2'd2,
    FN_FB   = 2'd3
  } fn_e;

  // Field order fixes the bit positions of the serial word (MSB first).
  typedef struct packed {
    logic [SEL_W-1:0]             sel_a;
    logic [SEL_W-1:0]             sel_b;
    logic                         inv_a;
    logic                         inv_b;
    fn_e                          fn;
    logic [0:NDIR-1][SEL_W-1:0]   route;  // index 0 = north, highest bits
  } cell_cfg_t;

  localparam int CFG_W = $bits(cell_cfg_t);
  localparam int CNT_W = $clog2(CFG_W + 1);
endpackage

// File: rtl/nbr_cfg_chain.sv
module nbr_cfg_chain
  import nbr_cell_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      cfg_en,
  input  logic      cfg_din,
  output cell_cfg_t cfg,
  output logic      ready
);
  logic [CFG_W-1:0] sh_q, sh_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             en_q;

  // Next state: shift and count only while the chain is enabled.
  always_comb begin
    sh_d  = sh_q;
    cnt_d = cnt_q;
    if (cfg_en) begin
      sh_d = {sh_q[CFG_W-2:0], cfg_din};
      if (!en_q) begin
        cnt_d = CNT_W'(1);
      end else if (cnt_q != CNT_W'(CFG_W)) begin
        cnt_d = cnt_q + CNT_W'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q  <= '0;
      cnt_q <= '0;
      en_q  <= 1'b0;
    end else begin
      if (cfg_en) begin
        sh_q  <= sh_d;
        cnt_q <= cnt_d;
      end
      en_q <= cfg_en;
    end
  end

  assign cfg   = cell_cfg_t'(sh_q);
  assign ready = (cnt_q == CNT_W'(CFG_W)) && !cfg_en;
endmodule

// File: rtl/nbr_in_pick.sv
module nbr_in_pick
  import nbr_cell_pkg::*;
(
  input  logic [NDIR-1:0]  nbr,
  input  logic [SEL_W-1:0] sel,
  input  logic             inv,
  output logic             op
);
  assign op = nbr[sel] ^ inv;
endmodule

// File: rtl/nbr_func.sv
module nbr_func
  import nbr_cell_pkg::*;
(
  input  logic op_a,
  input  logic op_b,
  input  fn_e  fn,
  input  logic fb,
  output logic res
);
  logic leg;

  always_comb begin
    case (fn)
      FN_ZERO: leg = 1'b0;
      FN_ONE:  leg = 1'b1;
      FN_NOTB: leg = ~op_b;
      FN_FB:   leg = fb;
    endcase
  end

  assign res = op_a ? op_b : leg;
endmodule

// File: rtl/nbr_route.sv
module nbr_route
  import nbr_cell_pkg::*;
#(
  parameter int DIR = 0
) (
  input  logic [NDIR-1:0]  nbr,
  input  logic [SEL_W-1:0] code,
  input  logic             res,
  input  logic             ready,
  output logic             o
);
  localparam logic [SEL_W-1:0] BASE = SEL_W'(DIR);
  logic [SEL_W-1:0] idx;

  assign idx = BASE + code;  // wraps modulo NDIR
  assign o   = ready && ((code == '0) ? res : nbr[idx]);
endmodule

// File: rtl/nbr_cell.sv
module nbr_cell
  import nbr_cell_pkg::*;
#(
  parameter bit FEEDBACK_REG = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cfg_en,
  input  logic cfg_din,
  input  logic in_n,
  input  logic in_e,
  input  logic in_s,
  input  logic in_w,
  output logic out_n,
  output logic out_e,
  output logic out_s,
  output logic out_w
);
  logic [1:0]      rsync_q;
  logic            rst_s;
  cell_cfg_t       cfg;
  logic            ready;
  logic [NDIR-1:0] nbr_in, nbr_out;
  logic            op_a, op_b, fn_out, fb_q;

  // Reset: asserted asynchronously, released after two clock edges.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= '0;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign rst_s = rsync_q[1];

  assign nbr_in = {in_w, in_s, in_e, in_n};

  nbr_cfg_chain u_chain (
    .clk(clk), .rst_n(rst_s), .cfg_en(cfg_en), .cfg_din(cfg_din),
    .cfg(cfg), .ready(ready)
  );

  nbr_in_pick u_pick_a (.nbr(nbr_in), .sel(cfg.sel_a), .inv(cfg.inv_a), .op(op_a));
  nbr_in_pick u_pick_b (.nbr(nbr_in), .sel(cfg.sel_b), .inv(cfg.inv_b), .op(op_b));

  nbr_func u_func (.op_a(op_a), .op_b(op_b), .fn(cfg.fn), .fb(fb_q), .res(fn_out));

  generate
    if (FEEDBACK_REG) begin : g_reg
      logic fb_d;
      always_comb fb_d = ready ? fn_out : fb_q;
      always_ff @(posedge clk or negedge rst_s) begin
        if (!rst_s) fb_q <= 1'b0;
        else        fb_q <= fb_d;
      end
    end else begin : g_lat
      logic lat_en;
      assign lat_en = ready && (cfg.fn == FN_FB) && op_a;
      always_latch begin
        if (!rst_s)      fb_q <= 1'b0;
        else if (lat_en) fb_q <= op_b;
      end
    end
  endgenerate

  generate
    for (genvar d = 0; d < NDIR; d++) begin : g_out
      nbr_route #(.DIR(d)) u_route (
        .nbr(nbr_in), .code(cfg.route[d]), .res(fn_out),
        .ready(ready), .o(nbr_out[d])
      );
    end
  endgenerate

  assign {out_w, out_s, out_e, out_n} = nbr_out;
endmodule

// File: rtl/nbr_cell_chk.sv
module nbr_cell_chk
  import nbr_cell_pkg::*;
#(
  parameter bit FEEDBACK_REG = 1'b0
) (
  input logic            clk,
  input logic            rst_s,
  input logic            cfg_en,
  input logic            cfg_din,
  input logic            cfg_lsb,
  input fn_e             fn,
  input logic [SEL_W-1:0] route_n,
  input logic [SEL_W-1:0] route_s,
  input logic            ready,
  input logic            op_a,
  input logic            op_b,
  input logic            res,
  input logic            in_e,
  input logic [NDIR-1:0] nbr_out
);
  p_load_zero_r2: assert property (@(posedge clk) disable iff (!rst_s)
    cfg_en |-> (nbr_out == '0));

  p_shift_in_r1: assert property (@(posedge clk) disable iff (!rst_s)
    cfg_en |=> (cfg_lsb == $past(cfg_din)));

  p_and_leg_r4: assert property (@(posedge clk) disable iff (!rst_s)
    (ready && fn == FN_ZERO) |-> (res == (op_a & op_b)));

  p_pass_north_r7: assert property (@(posedge clk) disable iff (!rst_s)
    (ready && route_n == SEL_W'(1)) |-> (nbr_out[0] == in_e));

  p_self_south_r7: assert property (@(posedge clk) disable iff (!rst_s)
    (ready && route_s == '0) |-> (nbr_out[2] == res));

  p_hold_r5: assert property (@(posedge clk) disable iff (!rst_s)
    (ready && $past(ready) && fn == FN_FB && !op_a && !$past(op_a)) |-> $stable(res));

  generate
    if (FEEDBACK_REG) begin : g_reg_chk
      p_edge_copy_r6: assert property (@(posedge clk) disable iff (!rst_s)
        (ready && $past(ready) && fn == FN_FB && !op_a) |-> (res == $past(res)));
    end
  endgenerate
endmodule

bind nbr_cell nbr_cell_chk #(.FEEDBACK_REG(FEEDBACK_REG)) u_chk (
  .clk(clk), .rst_s(rst_s), .cfg_en(cfg_en), .cfg_din(cfg_din),
  .cfg_lsb(cfg.route[3][0]), .fn(cfg.fn), .route_n(cfg.route[0]),
  .route_s(cfg.route[2]), .ready(ready), .op_a(op_a), .op_b(op_b),
  .res(fn_out), .in_e(in_e), .nbr_out(nbr_out)
);

// File: tb/test_nbr_cell.sv
module test_nbr_cell;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n, cfg_en, cfg_din, in_n, in_e, in_s, in_w;
  logic ln, le, ls, lw, rn, re, rs, rw;

  always #(CLK_PERIOD/2) clk = ~clk;

  nbr_cell #(.FEEDBACK_REG(1'b0)) i_nbr_cell (
    .clk(clk), .rst_n(rst_n), .cfg_en(cfg_en), .cfg_din(cfg_din),
    .in_n(in_n), .in_e(in_e), .in_s(in_s), .in_w(in_w),
    .out_n(ln), .out_e(le), .out_s(ls), .out_w(lw));

  nbr_cell #(.FEEDBACK_REG(1'b1)) i_nbr_cell_reg (
    .clk(clk), .rst_n(rst_n), .cfg_en(cfg_en), .cfg_din(cfg_din),
    .in_n(in_n), .in_e(in_e), .in_s(in_s), .in_w(in_w),
    .out_n(rn), .out_e(re), .out_s(rs), .out_w(rw));

  int    n_checks = 0;
  int    n_fail   = 0;
  string cur_req  = "R2";

  // Reference model state
  logic [15:0] m_sh;
  int          m_cnt;
  logic        m_enq, m_lat, m_ff;

  function automatic logic f_of(logic x, logic y, logic [1:0] fn, logic fb);
    logic leg;
    case (fn)
      2'd0: leg = 1'b0;
      2'd1: leg = 1'b1;
      2'd2: leg = ~y;
      default: leg = fb;
    endcase
    return x ? y : leg;
  endfunction

  function automatic logic [3:0] ins_now();
    return {in_w, in_s, in_e, in_n};
  endfunction

  function automatic logic m_ready();
    return (m_cnt == 16) && !cfg_en;
  endfunction

  function automatic logic [3:0] route_out(logic f, logic rdy);
    logic [3:0] ins = ins_now();
    logic [3:0] o;
    for (int d = 0; d < 4; d++) begin
      int c = int'(m_sh[7-2*d -: 2]);
      o[d] = !rdy ? 1'b0 : ((c == 0) ? f : ins[(d + c) % 4]);
    end
    return o;
  endfunction

  task automatic model_edge();
    logic [3:0] ins;
    logic x, y, rdy;
    if (!rst_n) begin
      m_sh = '0; m_cnt = 0; m_enq = 1'b0; m_lat = 1'b0; m_ff = 1'b0;
    end else begin
      ins = ins_now();
      x   = ins[m_sh[15:14]] ^ m_sh[11];
      y   = ins[m_sh[13:12]] ^ m_sh[10];
      rdy = m_ready();
      if (rdy) m_ff = f_of(x, y, m_sh[9:8], m_ff);
      if (cfg_en) begin
        m_sh = {m_sh[14:0], cfg_din};
        if (!m_enq) m_cnt = 1;
        else if (m_cnt < 16) m_cnt++;
      end
      m_enq = cfg_en;
    end
  endtask

  task automatic compare();
    logic [3:0] ins, exp_l, exp_r, got_l, got_r;
    logic x, y, rdy;
    ins = ins_now();
    x   = ins[m_sh[15:14]] ^ m_sh[11];
    y   = ins[m_sh[13:12]] ^ m_sh[10];
    rdy = m_ready();
    if (rdy && m_sh[9:8] == 2'd3 && x) m_lat = y;
    exp_l = route_out(f_of(x, y, m_sh[9:8], m_lat), rdy);
    exp_r = route_out(f_of(x, y, m_sh[9:8], m_ff), rdy);
    got_l = {lw, ls, le, ln};
    got_r = {rw, rs, re, rn};
    n_checks++;
    if (got_l !== exp_l) begin
      n_fail++;
      $display("FAIL %s latch cell outputs {w,s,e,n}: got %b expected %b", cur_req, got_l, exp_l);
    end
    n_checks++;
    if (got_r !== exp_r) begin
      n_fail++;
      $display("FAIL %s registered cell outputs {w,s,e,n}: got %b expected %b", cur_req, got_r, exp_r);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    model_edge();
    @(negedge clk);
    compare();
  endtask

  task automatic apply(logic [3:0] v);
    {in_w, in_s, in_e, in_n} = v;
    tick();
  endtask

  task automatic sweep();
    for (int v = 0; v < 16; v++) apply(4'(v));
  endtask

  task automatic load_n(logic [31:0] bits, int n);
    cfg_en = 1'b1;
    for (int i = n - 1; i >= 0; i--) begin
      cfg_din = bits[i];
      tick();
    end
    cfg_en  = 1'b0;
    cfg_din = 1'b0;
    tick();
  endtask

  function automatic logic [15:0] mk(logic [1:0] a, logic [1:0] b, logic ia, logic ib,
                                     logic [1:0] fn, logic [1:0] r_n, logic [1:0] r_e,
                                     logic [1:0] r_s, logic [1:0] r_w);
    return {a, b, ia, ib, fn, r_n, r_e, r_s, r_w};
  endfunction

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    rst_n = 1'b0; cfg_en = 1'b0; cfg_din = 1'b0;
    {in_w, in_s, in_e, in_n} = 4'b0000;
    m_sh = '0; m_cnt = 0; m_enq = 1'b0; m_lat = 1'b0; m_ff = 1'b0;

    // R9 R2: reset state, outputs silent
    cur_req = "R9";
    repeat (3) tick();
    rst_n = 1'b1;
    cur_req = "R2";
    repeat (3) tick();

    // R1 R4: A=north, B=east, function code 0, all routes drive result
    cur_req = "R1";
    load_n({16'h0, mk(2'd0, 2'd1, 1'b0, 1'b0, 2'd0, 2'd0, 2'd0, 2'd0, 2'd0)}, 16);
    cur_req = "R4";
    sweep();

    // R3 R4: A=~north, B=south, function code 1
    cur_req = "R3";
    load_n({16'h0, mk(2'd0, 2'd2, 1'b1, 1'b0, 2'd1, 2'd0, 2'd0, 2'd0, 2'd0)}, 16);
    sweep();
    // R3 R4: A=east, B=~west, function code 2
    load_n({16'h0, mk(2'd1, 2'd3, 1'b0, 1'b1, 2'd2, 2'd0, 2'd0, 2'd0, 2'd0)}, 16);
    cur_req = "R4";
    sweep();

    // R7: every route code appears on some side
    cur_req = "R10";
    load_n({16'h0, mk(2'd0, 2'd1, 1'b0, 1'b0, 2'd0, 2'd1, 2'd2, 2'd3, 2'd0)}, 16);
    cur_req = "R7";
    sweep();
    load_n({16'h0, mk(2'd2, 2'd3, 1'b0, 1'b0, 2'd1, 2'd3, 2'd1, 2'd0, 2'd2)}, 16);
    sweep();

    // R2: truncated load keeps outputs at 0
    cur_req = "R2";
    cfg_en = 1'b1;
    for (int i = 0; i < 8; i++) begin
      cfg_din = i[0];
      tick();
    end
    cfg_en = 1'b0;
    sweep();

    // R5 R6: feedback mode, A=west (enable), B=north (data), south passes north
    cur_req = "R10";
    load_n({16'h0, mk(2'd3, 2'd0, 1'b0, 1'b0, 2'd3, 2'd0, 2'd0, 2'd2, 2'd0)}, 16);
    cur_req = "R5 R6";
    apply(4'b1001);
    apply(4'b1000);
    apply(4'b1001);
    apply(4'b0001);  // enable drops, data 1 held
    apply(4'b0000);
    apply(4'b0001);
    apply(4'b0110);
    apply(4'b1000);  // transparent, 0
    apply(4'b0000);
    apply(4'b0001);  // held 0
    apply(4'b1001);
    apply(4'b0001);  // hold 1 again before reset

    // R9: reset clears the stored 1
    rst_n = 1'b0;
    repeat (2) tick();
    rst_n = 1'b1;
    repeat (3) tick();
    cur_req = "R9";
    load_n({16'h0, mk(2'd3, 2'd0, 1'b0, 1'b0, 2'd3, 2'd0, 2'd0, 2'd2, 2'd0)}, 16);
    apply(4'b0001);
    apply(4'b0011);

    // R8: 20 bits shifted, the first 4 are dropped
    cur_req = "R8";
    load_n({12'h0, 4'b1111, mk(2'd1, 2'd0, 1'b0, 1'b0, 2'd2, 2'd0, 2'd3, 2'd0, 2'd1)}, 20);
    sweep();

    finish_run();
  end
endmodule